// File: doc/BRIEF.md
# TMDS PHY Power-Up and Power-Down Sequencer

This block is the control engine that turns a TMDS transmitter PHY on and off. A start command latches a 32-bit pixel clock value in hertz. The TMDS clock is taken to be equal to the pixel clock, which assumes 24-bit colour and no pixel repetition. The block finds which frequency band that value falls in and derives the PLL input and output divider codes from the band. It then writes a PLL configuration word through a single-cycle register-write port and waits for the PLL to report lock. The wait has a bound that is counted in millisecond ticks.

Once lock arrives, the block programs three more registers in a fixed order: the serializer configuration, the current control and the calibration code. The serializer word depends on frequency. Source termination is switched on only above 165 MHz. A second, board-tuning table can OR extra swing and pre-emphasis bits into the word, but never the bits the sequencer owns itself.

A stop command powers the PHY down. It leaves only the two detection functions enabled, clears the PLL word, and then checks that lock falls away within the same bounded wait. Each sequence ends with a one-cycle done pulse or a one-cycle error pulse.

Top module: `phy_pwr_seq`

## Requirements
- R1: The latched pixel clock selects one of five bands, each including its lower bound and excluding its upper bound. The bands and their (input divider, output code) pairs are: below 20 MHz → (1, 3); 20 to 42.5 MHz → (2, 3); 42.5 to 85 MHz → (4, 2); 85 to 170 MHz → (8, 1); 170 to 340 MHz → (16, 0). Output codes 0 to 3 mean divide by 1, 2, 4 and 8. The first write goes to address 0x510 with this word: bit 0 = 1, bits 15:8 = 40, bits 23:16 = input divider, bits 31:24 = output code.
- R2: A pixel clock in no band, which includes every value of 340 MHz or more, ends the start sequence with an error pulse and no register write.
- R3: After the PLL write, no further write happens while lock is low. Once lock is seen high, the serializer write follows on the next cycle.
- R4: On a start, if lock is still low after TIMEOUT_MS millisecond ticks (default 50) counted from the PLL write, the sequence ends with an error and no further writes.
- R5: The serializer word written to 0x504 always has bits 0, 16, 18 and 19 set. Bit 24 is also set only when the TMDS clock is strictly above 165 MHz.
- R6: A tuning table matches with both bounds inclusive and the first matching entry wins. From 0 to 250 MHz the extra value is 0. From 250 to 300 MHz it is 0x1110. The extra value is ORed into the serializer word only after bits 0, 1, 16, 17, 18, 19 and 24 are cleared from it. Exactly 250 MHz therefore gets no extra bits.
- R7: After lock, the writes come in this order on consecutive cycles: 0x504, then 0x518 with data 0, then 0x520 with data 0. A done pulse follows.
- R8: A stop writes 0x000C0000 to 0x504 and then 0 to 0x510. It then waits for lock to go low and pulses done. If lock is still high after TIMEOUT_MS ticks, it pulses error instead.
- R9: Start and stop are ignored while busy, and so is a new pixel clock value. If start and stop arrive in the same idle cycle, start wins.
- R10: After reset, busy, done, error and the write strobe are all low. Done and error are single-cycle pulses that never occur together, and busy is low again on the cycle after either one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Power-up command pulse |
| stop_i | input | 1 | Power-down command pulse |
| pclk_hz_i | input | 32 | Pixel clock in Hz, latched on start |
| lock_i | input | 1 | PLL lock indication |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| wr_en_o | output | 1 | Register write strobe, one cycle per write |
| wr_addr_o | output | 12 | Register write address |
| wr_data_o | output | 32 | Register write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished without error (pulse) |
| err_o | output | 1 | Sequence failed (pulse) |

## Verification
A wrong band decode or a wrong divider field shows up in the very first write, two cycles after start. A wrong termination or tuning decision shows up in the serializer data one cycle after lock. A state machine that leaves its wait early shows up as a write, or a done pulse, while lock is still low. A timer that miscounts moves the error pulse away from the fiftieth tick. A state machine that is stuck shows as busy never falling and no done or error pulse. The band edges, the 165 MHz threshold and both tuning-table edges are each driven on both sides.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  localparam int NBANDS = 5;
  localparam int NXTRA  = 2;

  // band limits: low inclusive, high exclusive
  localparam logic [31:0] BAND_LO  [NBANDS] = '{32'd0, 32'd20_000_000, 32'd42_500_000,
                                                32'd85_000_000, 32'd170_000_000};
  localparam logic [31:0] BAND_HI  [NBANDS] = '{32'd20_000_000, 32'd42_500_000, 32'd85_000_000,
                                                32'd170_000_000, 32'd340_000_000};
  localparam logic [7:0]  BAND_IDF [NBANDS] = '{8'd1, 8'd2, 8'd4, 8'd8, 8'd16};
  localparam logic [1:0]  BAND_ODF [NBANDS] = '{2'd3, 2'd3, 2'd2, 2'd1, 2'd0};

  // tuning table: both limits inclusive, first match wins
  localparam logic [31:0] XTRA_LO  [NXTRA] = '{32'd0, 32'd250_000_000};
  localparam logic [31:0] XTRA_HI  [NXTRA] = '{32'd250_000_000, 32'd300_000_000};
  localparam logic [31:0] XTRA_SER [NXTRA] = '{32'h0000_0000, 32'h0000_1110};
  localparam logic [31:0] XTRA_CUR [NXTRA] = '{32'h0, 32'h0};
  localparam logic [31:0] XTRA_CAL [NXTRA] = '{32'h0, 32'h0};

  localparam logic [7:0]  FB_DIV       = 8'd40;
  localparam logic [31:0] TERM_ABOVE   = 32'd165_000_000;
  localparam logic [31:0] SER_ON_BITS  = 32'h000D_0001;  // enable, ext data, both detections
  localparam logic [31:0] SER_SRC_TERM = 32'h0100_0000;
  localparam logic [31:0] SER_OWNED    = 32'h010F_0003;  // bits the sequencer keeps for itself
  localparam logic [31:0] SER_OFF_BITS = 32'h000C_0000;  // detections only

  localparam logic [31:0] REG_SER = 32'h504;
  localparam logic [31:0] REG_PLL = 32'h510;
  localparam logic [31:0] REG_CUR = 32'h518;
  localparam logic [31:0] REG_CAL = 32'h520;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CHECK, ST_PLL_WR, ST_LOCK_WAIT, ST_SER_WR, ST_CUR_WR, ST_CAL_WR,
    ST_OFF_SER, ST_OFF_PLL, ST_UNLOCK_WAIT, ST_DONE, ST_FAIL
  } seq_state_e;

  function automatic logic [31:0] pll_word(input logic [7:0] idf, input logic [1:0] odf);
    return {6'b0, odf, idf, FB_DIV, 8'h01};
  endfunction

  function automatic logic [31:0] ser_word(input logic [31:0] hz, input logic xhit,
                                           input logic [31:0] xval);
    logic [31:0] w;
    w = SER_ON_BITS;
    if (hz > TERM_ABOVE) w = w | SER_SRC_TERM;
    if (xhit) w = w | (xval & ~SER_OWNED);
    return w;
  endfunction

endpackage

// File: rtl/lock_timer.sv
module lock_timer #(
  parameter int LIMIT = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt;

  assign expired_o = (cnt == CNT_W'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            cnt <= '0;
    else if (clr_i)                        cnt <= '0;
    else if (run_i && tick_i && !expired_o) cnt <= cnt + 1'b1;
  end

  assert_timer_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(LIMIT));
  assert_expire_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_o && !clr_i) |=> expired_o);
endmodule

// File: rtl/clk_band_map.sv
module clk_band_map
  import phy_seq_pkg::*;
(
  input  logic [31:0]       hz_i,
  output logic [NBANDS-1:0] band_hits_o,
  output logic              in_band_o,
  output logic [31:0]       pll_word_o,
  output logic [31:0]       ser_word_o,
  output logic [31:0]       cur_word_o,
  output logic [31:0]       cal_word_o
);
  logic [NXTRA-1:0] xhits;
  logic [7:0]       idf;
  logic [1:0]       odf;
  logic             xhit;
  logic [31:0]      xser;

  for (genvar b = 0; b < NBANDS; b++) begin : g_band
    if (b == 0) begin : g_first
      assign band_hits_o[b] = (hz_i < BAND_HI[b]);
    end else begin : g_rest
      assign band_hits_o[b] = (hz_i >= BAND_LO[b]) && (hz_i < BAND_HI[b]);
    end
  end

  for (genvar x = 0; x < NXTRA; x++) begin : g_xtra
    if (x == 0) begin : g_first
      assign xhits[x] = (hz_i <= XTRA_HI[x]);
    end else begin : g_rest
      assign xhits[x] = (hz_i >= XTRA_LO[x]) && (hz_i <= XTRA_HI[x]);
    end
  end

  always_comb begin
    in_band_o = 1'b0;
    idf       = '0;
    odf       = '0;
    for (int b = NBANDS - 1; b >= 0; b--) begin
      if (band_hits_o[b]) begin
        in_band_o = 1'b1;
        idf       = BAND_IDF[b];
        odf       = BAND_ODF[b];
      end
    end
  end

  always_comb begin
    xhit       = 1'b0;
    xser       = '0;
    cur_word_o = '0;
    cal_word_o = '0;
    for (int x = NXTRA - 1; x >= 0; x--) begin
      if (xhits[x]) begin
        xhit       = 1'b1;
        xser       = XTRA_SER[x];
        cur_word_o = XTRA_CUR[x];
        cal_word_o = XTRA_CAL[x];
      end
    end
  end

  assign pll_word_o = pll_word(idf, odf);
  assign ser_word_o = ser_word(hz_i, xhit, xser);
endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
  import phy_seq_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int TIMEOUT_MS = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [31:0]       pclk_hz_i,
  input  logic              lock_i,
  input  logic              ms_tick_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [31:0]       wr_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  seq_state_e       state, state_nx;
  logic [31:0]      tmds_q;
  logic [NBANDS-1:0] band_hits;
  logic             in_band, expired, waiting, timer_clr;
  logic [31:0]      pll_w, ser_w, cur_w, cal_w;

  clk_band_map u_map (
    .hz_i(tmds_q), .band_hits_o(band_hits), .in_band_o(in_band),
    .pll_word_o(pll_w), .ser_word_o(ser_w), .cur_word_o(cur_w), .cal_word_o(cal_w)
  );

  assign waiting   = (state == ST_LOCK_WAIT) || (state == ST_UNLOCK_WAIT);
  assign timer_clr = (state == ST_PLL_WR) || (state == ST_OFF_PLL);

  lock_timer #(.LIMIT(TIMEOUT_MS)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(timer_clr), .run_i(waiting),
    .tick_i(ms_tick_i), .expired_o(expired)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:        if (start_i) state_nx = ST_CHECK;
                      else if (stop_i) state_nx = ST_OFF_SER;
      ST_CHECK:       state_nx = in_band ? ST_PLL_WR : ST_FAIL;
      ST_PLL_WR:      state_nx = ST_LOCK_WAIT;
      ST_LOCK_WAIT:   if (lock_i) state_nx = ST_SER_WR;
                      else if (expired) state_nx = ST_FAIL;
      ST_SER_WR:      state_nx = ST_CUR_WR;
      ST_CUR_WR:      state_nx = ST_CAL_WR;
      ST_CAL_WR:      state_nx = ST_DONE;
      ST_OFF_SER:     state_nx = ST_OFF_PLL;
      ST_OFF_PLL:     state_nx = ST_UNLOCK_WAIT;
      ST_UNLOCK_WAIT: if (!lock_i) state_nx = ST_DONE;
                      else if (expired) state_nx = ST_FAIL;
      default:        state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      tmds_q <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_IDLE && start_i) tmds_q <= pclk_hz_i;
    end
  end

  always_comb begin
    wr_en_o   = 1'b1;
    wr_addr_o = '0;
    wr_data_o = '0;
    case (state)
      ST_PLL_WR:  begin wr_addr_o = ADDR_W'(REG_PLL); wr_data_o = pll_w;        end
      ST_SER_WR:  begin wr_addr_o = ADDR_W'(REG_SER); wr_data_o = ser_w;        end
      ST_CUR_WR:  begin wr_addr_o = ADDR_W'(REG_CUR); wr_data_o = cur_w;        end
      ST_CAL_WR:  begin wr_addr_o = ADDR_W'(REG_CAL); wr_data_o = cal_w;        end
      ST_OFF_SER: begin wr_addr_o = ADDR_W'(REG_SER); wr_data_o = SER_OFF_BITS; end
      ST_OFF_PLL: begin wr_addr_o = ADDR_W'(REG_PLL); wr_data_o = '0;           end
      default:    wr_en_o = 1'b0;
    endcase
  end

  assign busy_o = (state != ST_IDLE);
  assign done_o = (state == ST_DONE);
  assign err_o  = (state == ST_FAIL);

  assert_band_unique_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(band_hits));
  assert_pll_in_band_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_addr_o == ADDR_W'(REG_PLL) && wr_data_o != 0) |-> $onehot(band_hits));
  assert_quiet_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !wr_en_o);
  assert_lock_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOCK_WAIT && lock_i) |=> (wr_en_o && wr_addr_o == ADDR_W'(REG_SER)));
  assert_write_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> busy_o);
  assert_stuck_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_UNLOCK_WAIT && lock_i && expired) |=> err_o);
  assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));
  assert_end_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |=> (!busy_o && !done_o && !err_o));
endmodule

// File: tb/test_phy_pwr_seq.sv
module test_phy_pwr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, stop = 1'b0, lock = 1'b0, tick = 1'b0;
  logic [31:0] pclk = '0;
  logic        wr_en, busy, done, err;
  logic [11:0] wr_addr;
  logic [31:0] wr_data;

  always #4 clk = ~clk;  // 125 MHz

  phy_pwr_seq i_phy_pwr_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop), .pclk_hz_i(pclk),
    .lock_i(lock), .ms_tick_i(tick), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .busy_o(busy), .done_o(done), .err_o(err)
  );

  int checks = 0, fails = 0;
  logic [11:0] la [8];
  logic [31:0] ld [8];
  int nwr = 0, ndone = 0, nerr = 0, nticks = 0, wide = 0;
  logic prev_pulse = 1'b0;

  // millisecond tick, one cycle in four
  initial forever begin
    repeat (3) @(posedge clk);
    #1 tick = 1'b1;
    @(posedge clk);
    #1 tick = 1'b0;
  end

  always @(negedge clk) begin
    if (wr_en) begin
      if (nwr < 8) begin la[nwr] = wr_addr; ld[nwr] = wr_data; end
      nwr++;
    end
    if (done) ndone++;
    if (err) nerr++;
    if ((done || err) && prev_pulse) wide++;
    prev_pulse = done || err;
    if (busy && tick) nticks++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    nwr = 0; ndone = 0; nerr = 0; nticks = 0; wide = 0;
  endtask

  task automatic cmd(input bit s, input bit p);
    @(posedge clk); #1 start = s; stop = p;
    @(posedge clk); #1 start = 1'b0; stop = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      if (!busy) break;
    end
    @(posedge clk); #1;
  endtask

  // {pixel clock, PLL word, serializer word, error expected}
  localparam logic [96:0] VEC [16] = '{
    {32'd0,           32'h0301_2801, 32'h000D_0001, 1'b0},
    {32'd19_999_999,  32'h0301_2801, 32'h000D_0001, 1'b0},
    {32'd20_000_000,  32'h0302_2801, 32'h000D_0001, 1'b0},
    {32'd42_499_999,  32'h0302_2801, 32'h000D_0001, 1'b0},
    {32'd42_500_000,  32'h0204_2801, 32'h000D_0001, 1'b0},
    {32'd85_000_000,  32'h0108_2801, 32'h000D_0001, 1'b0},
    {32'd165_000_000, 32'h0108_2801, 32'h000D_0001, 1'b0},
    {32'd165_000_001, 32'h0108_2801, 32'h010D_0001, 1'b0},
    {32'd170_000_000, 32'h0010_2801, 32'h010D_0001, 1'b0},
    {32'd250_000_000, 32'h0010_2801, 32'h010D_0001, 1'b0},
    {32'd250_000_001, 32'h0010_2801, 32'h010D_1111, 1'b0},
    {32'd300_000_000, 32'h0010_2801, 32'h010D_1111, 1'b0},
    {32'd300_000_001, 32'h0010_2801, 32'h010D_0001, 1'b0},
    {32'd339_999_999, 32'h0010_2801, 32'h010D_0001, 1'b0},
    {32'd340_000_000, 32'h0,         32'h0,         1'b1},
    {32'hFFFF_FFFF,   32'h0,         32'h0,         1'b1}
  };

  task automatic check_power_up(input logic [31:0] pll_exp, input logic [31:0] ser_exp);
    chk(nwr == 4, "R7 write count", nwr, 4);
    chk(la[0] == 12'h510 && ld[0] == pll_exp, "R1 PLL write", {la[0][7:0], ld[0][23:0]}, pll_exp);
    chk(la[1] == 12'h504 && ld[1] == ser_exp, "R5 R6 serializer write", ld[1], ser_exp);
    chk(la[2] == 12'h518 && ld[2] == 0, "R7 current control write", {la[2], ld[2][19:0]}, 32'h5180_0000);
    chk(la[3] == 12'h520 && ld[3] == 0, "R7 calibration write", {la[3], ld[3][19:0]}, 32'h5200_0000);
    chk(ndone == 1 && nerr == 0, "R3 done without error", {ndone[15:0], nerr[15:0]}, 32'h0001_0000);
    chk(wide == 0, "R10 single-cycle pulse", wide, 0);
  endtask

  initial begin
    repeat (100_000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !wr_en, "R10 state in reset", {busy, done, err, wr_en}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !wr_en, "R10 state after reset", {busy, done, err, wr_en}, 0);

    // vector table: R1 R2 R5 R6 R7
    for (int i = 0; i < 16; i++) begin
      @(posedge clk); #1 lock = 1'b0; pclk = VEC[i][96:65];
      clear_log();
      cmd(1'b1, 1'b0);
      repeat (5) @(posedge clk);
      #1 lock = 1'b1;
      wait_idle();
      if (VEC[i][0]) begin
        chk(nwr == 0, "R2 no write out of band", nwr, 0);
        chk(nerr == 1 && ndone == 0, "R2 error pulse", {ndone[15:0], nerr[15:0]}, 1);
      end else begin
        check_power_up(VEC[i][64:33], VEC[i][32:1]);
      end
    end

    // R3: no progress while lock low, R9: commands ignored while busy
    @(posedge clk); #1 lock = 1'b0; pclk = 32'd100_000_000;
    clear_log();
    cmd(1'b1, 1'b1);   // simultaneous: start wins
    repeat (10) @(posedge clk);
    #1 pclk = 32'd300_000_000;
    cmd(1'b0, 1'b1);
    cmd(1'b1, 1'b0);
    repeat (20) @(negedge clk);
    chk(nwr == 1 && busy, "R3 held in lock wait", nwr, 1);
    chk(la[0] == 12'h510, "R9 start beats stop", la[0], 12'h510);
    @(posedge clk); #1 lock = 1'b1;
    wait_idle();
    check_power_up(32'h0108_2801, 32'h000D_0001);  // R9: 100 MHz settings kept

    // R4: lock never arrives
    @(posedge clk); #1 lock = 1'b0; pclk = 32'd50_000_000;
    clear_log();
    cmd(1'b1, 1'b0);
    wait_idle();
    chk(nerr == 1 && ndone == 0, "R4 timeout error", nerr, 1);
    chk(nwr == 1, "R4 only PLL written", nwr, 1);
    chk(nticks >= 50 && nticks <= 52, "R4 timeout length", nticks, 50);

    // R8: clean power-down
    @(posedge clk); #1 lock = 1'b1;
    clear_log();
    cmd(1'b0, 1'b1);
    repeat (6) @(posedge clk);
    #1 lock = 1'b0;
    wait_idle();
    chk(nwr == 2, "R8 stop write count", nwr, 2);
    chk(la[0] == 12'h504 && ld[0] == 32'h000C_0000, "R8 detections only", ld[0], 32'h000C_0000);
    chk(la[1] == 12'h510 && ld[1] == 0, "R8 PLL cleared", {la[1], ld[1][19:0]}, 32'h5100_0000);
    chk(ndone == 1 && nerr == 0, "R8 stop done", ndone, 1);

    // R8: lock refuses to drop
    @(posedge clk); #1 lock = 1'b1;
    clear_log();
    cmd(1'b0, 1'b1);
    wait_idle();
    chk(nerr == 1 && ndone == 0, "R8 stuck lock error", nerr, 1);
    chk(nwr == 2 && nticks >= 50, "R8 stuck lock wait", nticks, 50);
    chk(!busy && !done && !err, "R10 idle at end", {busy, done, err}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule